// File: doc/BRIEF.md
# Asynchronous Strobe-Driven Register Bus Slave

This block lets an external 8-bit processor read and write a small internal register bank over an asynchronous bus with separate strobes. The processor presents an address and pulses an active-high address-latch strobe. A rising edge of that strobe opens a new bus cycle, and the address the bus carried while the strobe was high is held once the strobe falls. The processor then asserts either the active-low read strobe or the active-low write strobe. It waits for the active-low ready output to go low, then releases the strobe.

Every strobe is brought into the internal clock domain through a synchronizer before any edge is acted on. A read drives the selected register onto the output data lane. The output enable is on only while the read strobe is low and the data-bus enable input is also low. A write takes the bus value that was present while the write strobe was low and stores it when the strobe returns high. A cycle where both strobes are asserted together is treated as a bus fault and does nothing. The bidirectional bus is split into an input lane, an output lane and an output enable, so the pad ring builds the tri-state driver. There is no streaming data path, so every pin is a plain control or data pin with no back-pressure.

Top module: `abus_slave`

## Requirements
- R1: After reset, ready_n is 1, data_oe is 0 and all 16 registers read back as 0x00.
- R2: The address is taken from addr_in while ale is high. Changes on addr_in after ale has fallen do not alter the register the cycle targets.
- R3: A read of an address returns the last value written to that register on data_out. While ready_n is low in a read with dben_n low, data_oe is 1.
- R4: With dben_n held high during a read, data_oe stays 0 even after ready_n goes low. Pulling dben_n low afterwards in the same read enables the output.
- R5: When rd_n returns high, data_oe drops at once, with no clock edge needed. ready_n is back to 1 within three clock edges after the rise of the strobe.
- R6: ready_n goes low exactly WAIT_CYC+3 clock edges after a strobe falls: two synchronizer edges, one detect edge and WAIT_CYC wait edges. It is still high after WAIT_CYC+2 edges.
- R7: A write stores the value that data_in held while wr_n was low into the addressed register when wr_n rises. No other register changes.
- R8: If rd_n and wr_n are asserted together in a cycle, ready_n never goes low, data_oe stays 0 and no register changes.
- R9: A strobe with no rising edge of ale since the previous cycle ended is ignored, and ready_n stays high.
- R10: Only the low 4 bits of the latched address select a register. For example, address 0x13 selects the same register as 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address-latch strobe, active high; its rise opens a cycle |
| addr_in | input | 8 | Processor address bus |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dben_n | input | 1 | Data-bus enable, active low; gates read driving |
| data_in | input | 8 | Input lane of the bidirectional data bus |
| data_out | output | 8 | Output lane of the bidirectional data bus |
| data_oe | output | 1 | Output enable for the data bus driver |
| ready_n | output | 1 | Ready, active low; low once the cycle may end |

## Verification
A table of writes and reads covers several addresses. These include the top register and an aliased address above 15, which separates correct index slicing from full-address decoding. It also reads back an unwritten register, which shows that reset clears the bank. Each bus cycle changes addr_in right after ale falls, so a design that tracks the live address rather than the held one returns wrong data. Directed cycles count the clock edges to ready, hold dben_n high and then low within one read, drive both strobes at once, and issue a strobe with no address phase. Each of these isolates one rule of the sequencer.

// File: rtl/abus_pkg.sv
package abus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RD_WAIT,
    ST_RD_DONE,
    ST_WR_WAIT,
    ST_WR_DONE,
    ST_CLASH
  } bus_state_e;
endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= '0;
          else        chain[gi] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= '0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/abus_addr_hold.sv
module abus_addr_hold #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              ale_q;
  logic              addr_hi_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ale_q  <= 1'b0;
    end else begin
      ale_q <= ale;
      if (ale) addr_q <= addr_in;
    end
  end

  assign idx_o          = addr_q[IDX_W-1:0];
  assign addr_hi_unused = ^addr_q[ADDR_W-1:IDX_W] ^ ale_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !ale_q) |=> $stable(addr_q));
endmodule

// File: rtl/abus_regfile.sv
module abus_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           mem[gi] <= '0;
        else if (we && widx == IDX_W'(gi))    mem[gi] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem[ridx];
endmodule

// File: rtl/abus_seq.sv
module abus_seq
  import abus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 2,
  localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_s,
  input  logic              rd_act,
  input  logic              wr_act,
  input  logic              rd_n_raw,
  input  logic              dben_n,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_commit,
  output logic              ready_n,
  output logic              data_oe
);
  bus_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rdata_q;
  logic              ale_prev_q;
  logic              ale_rise;
  logic              cap;
  logic              rd_phase;
  logic              cnt_end;

  assign ale_rise = ale_s & ~ale_prev_q;
  assign cnt_end  = (cnt_q == CNT_W'(WAIT_CYC - 1));

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cap       = 1'b0;
    wr_commit = 1'b0;
    unique case (st_q)
      ST_IDLE: if (ale_rise) st_d = ST_ARMED;
      ST_ARMED: begin
        if (rd_act && wr_act) st_d = ST_CLASH;
        else if (rd_act) begin
          st_d  = ST_RD_WAIT;
          cnt_d = '0;
          cap   = 1'b1;
        end else if (wr_act) begin
          st_d  = ST_WR_WAIT;
          cnt_d = '0;
        end
      end
      ST_RD_WAIT: begin
        if (wr_act)       st_d = ST_CLASH;
        else if (!rd_act) st_d = ST_IDLE;
        else if (cnt_end) st_d = ST_RD_DONE;
        else              cnt_d = cnt_q + 1'b1;
      end
      ST_RD_DONE: begin
        if (wr_act)       st_d = ST_CLASH;
        else if (!rd_act) st_d = ST_IDLE;
      end
      ST_WR_WAIT: begin
        if (rd_act)       st_d = ST_CLASH;
        else if (!wr_act) st_d = ST_IDLE;
        else if (cnt_end) st_d = ST_WR_DONE;
        else              cnt_d = cnt_q + 1'b1;
      end
      ST_WR_DONE: begin
        if (rd_act) st_d = ST_CLASH;
        else if (!wr_act) begin
          st_d      = ST_IDLE;
          wr_commit = 1'b1;
        end
      end
      ST_CLASH: if (!rd_act && !wr_act) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rdata_q    <= '0;
      ale_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      ale_prev_q <= ale_s;
      if (cap) rdata_q <= rdata_i;
    end
  end

  assign rd_phase = (st_q == ST_RD_WAIT) || (st_q == ST_RD_DONE);
  assign ready_n  = !((st_q == ST_RD_DONE) || (st_q == ST_WR_DONE));
  assign data_oe  = rd_phase & ~rd_n_raw & ~dben_n;
  assign rdata_o  = rdata_q;

  // R6
  ready_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> ($past(cnt_q) == CNT_W'(WAIT_CYC - 1)));

  // R8
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && wr_act) |=> ready_n);

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && !rd_act) |=> !rd_phase);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && $past(rd_phase)) |-> $stable(rdata_q));
endmodule

// File: rtl/abus_slave.sv
module abus_slave #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int WAIT_CYC = 2,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              dben_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ready_n
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [2:0]        strobe_s;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_commit;

  abus_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ale, ~rd_n, ~wr_n}),
    .sync_o  (strobe_s)
  );

  abus_addr_hold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .addr_in (addr_in),
    .idx_o   (idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wdata_q <= '0;
    else if (!wr_n) wdata_q <= data_in;
  end

  abus_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_commit),
    .widx  (idx),
    .wdata (wdata_q),
    .ridx  (idx),
    .rdata (reg_rdata)
  );

  abus_seq #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale_s     (strobe_s[2]),
    .rd_act    (strobe_s[1]),
    .wr_act    (strobe_s[0]),
    .rd_n_raw  (rd_n),
    .dben_n    (dben_n),
    .rdata_i   (reg_rdata),
    .rdata_o   (data_out),
    .wr_commit (wr_commit),
    .ready_n   (ready_n),
    .data_oe   (data_oe)
  );

  // R3
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!rd_n && !dben_n));

  // R7
  commit_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !ready_n);
endmodule

// File: tb/abus_slave_test.sv
module abus_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] addr_in = '0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       dben_n = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       ready_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  abus_slave #(.WAIT_CYC(WAIT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr_in(addr_in),
    .rd_n(rd_n), .wr_n(wr_n), .dben_n(dben_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ready_n(ready_n)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 8'h00, 8'h5A}, '{1'b1, 8'h05, 8'hC3}, '{1'b1, 8'h0F, 8'hFF},
    '{1'b1, 8'h13, 8'h7E}, '{1'b1, 8'hA7, 8'h21}, '{1'b0, 8'h00, 8'h00},
    '{1'b0, 8'h05, 8'h00}, '{1'b0, 8'h0F, 8'h00}, '{1'b0, 8'h03, 8'h00},
    '{1'b0, 8'h07, 8'h00}, '{1'b0, 8'h09, 8'h00}, '{1'b0, 8'hF5, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [7:0] a);
    @(negedge clk); ale = 1'b1; addr_in = a;
    repeat (3) @(negedge clk);
    ale = 1'b0;
    @(negedge clk); addr_in = ~a;   // R2: live address moves after ale falls
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 40 && ready_n; n++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    latch_addr(a);
    @(negedge clk); data_in = d; wr_n = 1'b0;
    wait_ready();
    chk(ready_n == 1'b0, "R7 write ready", ready_n, 0);
    @(negedge clk); wr_n = 1'b1; data_in = ~d;
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b1, "R5 ready release after write", ready_n, 1);
    model[a[3:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    latch_addr(a);
    @(negedge clk); rd_n = 1'b0;
    wait_ready();
    d = data_out;
    chk(data_oe == 1'b1, "R3 oe during read", data_oe, 1);
    @(negedge clk); rd_n = 1'b1;
    #1 chk(data_oe == 1'b0, "R5 oe drops on rd_n rise", data_oe, 0);
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b1, "R5 ready release after read", ready_n, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready_n == 1'b1, "R1 ready_n after reset", ready_n, 1);
    chk(data_oe == 1'b0, "R1 data_oe after reset", data_oe, 0);

    // table walk: R2, R3, R7, R10, R1 (unwritten reads zero)
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr, rd);
        chk(rd == model[VECS[i].addr[3:0]], "R3 R10 R2 read data", rd,
            model[VECS[i].addr[3:0]]);
      end
    end

    // R6 exact ready latency
    latch_addr(8'h05);
    @(negedge clk); rd_n = 1'b0;
    repeat (WAIT_CYC + 2) @(negedge clk);
    chk(ready_n == 1'b1, "R6 ready still high", ready_n, 1);
    @(negedge clk);
    chk(ready_n == 1'b0, "R6 ready low on time", ready_n, 0);
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 dben_n gates output
    latch_addr(8'h0F);
    @(negedge clk); dben_n = 1'b1; rd_n = 1'b0;
    wait_ready();
    chk(ready_n == 1'b0, "R4 ready with dben high", ready_n, 0);
    chk(data_oe == 1'b0, "R4 oe blocked by dben_n", data_oe, 0);
    dben_n = 1'b0;
    #1 chk(data_oe == 1'b1, "R4 oe after dben_n low", data_oe, 1);
    chk(data_out == model[15], "R4 data after dben_n low", data_out, model[15]);
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 both strobes together
    latch_addr(8'h00);
    @(negedge clk); data_in = 8'h99; rd_n = 1'b0; wr_n = 1'b0;
    begin
      int lows = 0, oes = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!ready_n) lows++;
        if (data_oe) oes++;
      end
      chk(lows == 0, "R8 ready never low on clash", lows, 0);
      chk(oes == 0, "R8 oe never on clash", oes, 0);
    end
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(8'h00, rd);
    chk(rd == model[0], "R8 register unchanged after clash", rd, model[0]);

    // R9 strobe without address phase
    @(negedge clk); rd_n = 1'b0;
    begin
      int lows = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (!ready_n) lows++;
      end
      chk(lows == 0, "R9 strobe without ale ignored", lows, 0);
    end
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 only target register changes
    do_write(8'h09, 8'h3C);
    do_read(8'h08, rd);
    chk(rd == model[8], "R7 neighbour untouched", rd, model[8]);
    do_read(8'h09, rd);
    chk(rd == 8'h3C, "R7 written value", rd, 8'h3C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule